// File: doc/BRIEF.md
# Dual-byte timer with variable-length PWM

This block is a 16-bit counter split into a low byte and a high byte. A two-bit mode field chooses how the halves work: as two separate 8-bit interval timers, as an 8-bit interval timer beside an 8-bit pulse-width modulator, as one 16-bit interval timer, or as one pulse-width modulator whose counter length is set anywhere from 9 to 16 bits. When the halves are joined, a rate bit lets the counter step on every clock instead of once per machine cycle. The clock runs at twice the machine-cycle rate, and `cyc_stb` marks one clock in each machine cycle.

Software configures the block through byte writes to a small write-only register set. The block drives one modulated output. It also drives one shared interrupt request, which is the OR of two sticky event flags, one per half. Duty and length values are double-buffered, so a change never cuts a modulation period short.

Top module: `tp_timer_pwm`

## Requirements
- R1: After reset all counters are zero, every register reads as zero, and `pwm_out`, `flag_lo`, `flag_hi` and `irq` are all low.
- R2: In mode 0, each half is an interval timer. It advances once per `cyc_stb` clock from 0 up to its own period byte. On the step after it reaches that byte it returns to 0 and sets its own flag (low half sets `flag_lo`, high half sets `flag_hi`). The two halves run independently.
- R3: In mode 1, the low half is the timer of R2. The high half counts 0 to 255 on `cyc_stb` clocks. `pwm_out` is high while the high count is below the high duty byte. Every return to 0 sets `flag_hi`.
- R4: In mode 2, the two halves form one 16-bit timer. It counts up to {high period, low period}, then returns to 0 and sets `flag_hi` only.
- R5: In modes 0 and 1, counting happens only on clocks where `cyc_stb` is high, whatever the value of the rate bit.
- R6: In modes 2 and 3, a rate bit of 1 makes the counter advance on every clock. A rate bit of 0 makes it advance only on `cyc_stb` clocks.
- R7: In mode 3, with length field L, the counter is N = 9+L bits wide. It returns to 0 after reaching 2^N−1 and sets `flag_hi` on each return. `pwm_out` is high while the count is below the 16-bit value {high duty, low duty}.
- R8: A duty of 0 keeps `pwm_out` low for the whole period. `pwm_out` is always low in modes 0 and 2, and also whenever the high-half run bit is 0.
- R9: Duty and length writes take effect only when the modulation counter returns to 0. While the high-half run bit is 0, they take effect on the next clock. A stopped half holds its count at 0.
- R10: A flag stays set until it is cleared by a write to address 6: data bit 0 clears `flag_lo` and data bit 1 clears `flag_hi`. If a set and a clear fall in the same clock, the set wins. `irq` is high whenever either flag is set.
- R11: Register map, written with `wr_en` high for one clock:
  - Address 0 is control. Bits [1:0] hold the mode, bit 2 the rate, bit 3 the low run bit and bit 4 the high run bit. In modes 2 and 3 only the high run bit applies.
  - Address 1 holds the length field in bits [2:0].
  - Addresses 2 and 3 hold the low and high period bytes.
  - Addresses 4 and 5 hold the low and high duty bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the machine-cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | High on one clock per machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Shared interrupt request |
| flag_lo | output | 1 | Low-half event flag |
| flag_hi | output | 1 | High-half event flag |

## Verification
A counter that is wrong by even one step first shows up as a flag rising one clock early or late. That happens at the next wrap, so within one programmed period. In the modulating modes, a wrong count also moves the falling edge of `pwm_out` within the same period. A duty or length shadow loaded at the wrong moment shows up as an output high time that differs from the expected one, in the first period after the write. Because the outputs are compared with a behavioural model on every clock, each fault is reported on the first clock where it differs.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int HALF_W  = 8;
    localparam int FULL_W  = 2 * HALF_W;
    localparam int LEN_W   = $clog2(HALF_W);
    localparam int ADDR_W  = 3;
    localparam int NFLAG   = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_LEN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_PER_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_DTY_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_DTY_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd6;

    typedef enum logic [1:0] {
        MODE_DUAL8   = 2'd0,
        MODE_T8_PWM8 = 2'd1,
        MODE_T16     = 2'd2,
        MODE_VPWM    = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic              fast;
        logic              run_lo;
        logic              run_hi;
        logic [LEN_W-1:0]  len;
        logic [HALF_W-1:0] per_lo;
        logic [HALF_W-1:0] per_hi;
        logic [HALF_W-1:0] duty_lo;
        logic [HALF_W-1:0] duty_hi;
    } cfg_t;
endpackage

// File: rtl/tp_regs.sv
module tp_regs
    import tp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic [NFLAG-1:0]  clr
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    cfg_d.mode   = mode_e'(wr_data[1:0]);
                    cfg_d.fast   = wr_data[2];
                    cfg_d.run_lo = wr_data[3];
                    cfg_d.run_hi = wr_data[4];
                end
                A_LEN:    cfg_d.len     = wr_data[LEN_W-1:0];
                A_PER_LO: cfg_d.per_lo  = wr_data;
                A_PER_HI: cfg_d.per_hi  = wr_data;
                A_DTY_LO: cfg_d.duty_lo = wr_data;
                A_DTY_HI: cfg_d.duty_hi = wr_data;
                A_CLR:    clr           = wr_data[NFLAG-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/tp_count.sv
module tp_count
    import tp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              cyc_stb,
    output logic [FULL_W-1:0] cnt,
    output logic [FULL_W-1:0] duty_sh,
    output logic [LEN_W-1:0]  len_sh,
    output logic              wrap_lo,
    output logic              wrap_hi
);
    localparam int LEN_BASE = HALF_W + 1;

    typedef struct packed {
        logic [FULL_W-1:0] cnt;
        logic [FULL_W-1:0] duty;
        logic [LEN_W-1:0]  len;
    } st_t;

    st_t st_d, st_q;
    logic [HALF_W-1:0] lo, hi;
    logic [FULL_W:0]   span;
    logic [FULL_W-1:0] top_val;
    logic              en_wide;

    assign lo      = st_q.cnt[HALF_W-1:0];
    assign hi      = st_q.cnt[FULL_W-1:HALF_W];
    assign span    = {{FULL_W{1'b0}}, 1'b1} << (LEN_BASE + int'(st_q.len));
    assign top_val = span[FULL_W-1:0] - 1'b1;
    assign en_wide = cfg.fast | cyc_stb;

    always_comb begin
        st_d    = st_q;
        wrap_lo = 1'b0;
        wrap_hi = 1'b0;
        if (!cfg.run_hi) begin
            st_d.duty = {cfg.duty_hi, cfg.duty_lo};
            st_d.len  = cfg.len;
        end
        case (cfg.mode)
            MODE_DUAL8, MODE_T8_PWM8: begin
                if (!cfg.run_lo) begin
                    st_d.cnt[HALF_W-1:0] = '0;
                end else if (cyc_stb) begin
                    if (lo >= cfg.per_lo) begin
                        st_d.cnt[HALF_W-1:0] = '0;
                        wrap_lo = 1'b1;
                    end else begin
                        st_d.cnt[HALF_W-1:0] = lo + 1'b1;
                    end
                end
                if (!cfg.run_hi) begin
                    st_d.cnt[FULL_W-1:HALF_W] = '0;
                end else if (cyc_stb) begin
                    if ((cfg.mode == MODE_DUAL8) ? (hi >= cfg.per_hi) : (hi == '1)) begin
                        st_d.cnt[FULL_W-1:HALF_W] = '0;
                        wrap_hi = 1'b1;
                        if (cfg.mode == MODE_T8_PWM8)
                            st_d.duty[FULL_W-1:HALF_W] = cfg.duty_hi;
                    end else begin
                        st_d.cnt[FULL_W-1:HALF_W] = hi + 1'b1;
                    end
                end
            end
            MODE_T16: begin
                if (!cfg.run_hi) begin
                    st_d.cnt = '0;
                end else if (en_wide) begin
                    if (st_q.cnt >= {cfg.per_hi, cfg.per_lo}) begin
                        st_d.cnt = '0;
                        wrap_hi  = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (!cfg.run_hi) begin
                    st_d.cnt = '0;
                end else if (en_wide) begin
                    if (st_q.cnt >= top_val) begin
                        st_d.cnt  = '0;
                        wrap_hi   = 1'b1;
                        st_d.duty = {cfg.duty_hi, cfg.duty_lo};
                        st_d.len  = cfg.len;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign duty_sh = st_q.duty;
    assign len_sh  = st_q.len;
endmodule

// File: rtl/tp_pwmcmp.sv
module tp_pwmcmp
    import tp_pkg::*;
(
    input  mode_e             mode,
    input  logic              run_hi,
    input  logic [FULL_W-1:0] cnt,
    input  logic [FULL_W-1:0] duty_sh,
    output logic              pwm
);
    logic below_byte, below_wide;

    assign below_byte = cnt[FULL_W-1:HALF_W] < duty_sh[FULL_W-1:HALF_W];
    assign below_wide = cnt < duty_sh;

    always_comb begin
        case (mode)
            MODE_T8_PWM8: pwm = run_hi & below_byte;
            MODE_VPWM:    pwm = run_hi & below_wide;
            default:      pwm = 1'b0;
        endcase
    end
endmodule

// File: rtl/tp_flags.sv
module tp_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
endmodule

// File: rtl/tp_timer_pwm.sv
module tp_timer_pwm
    import tp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              irq,
    output logic              flag_lo,
    output logic              flag_hi
);
    cfg_t              cfg;
    logic [NFLAG-1:0]  clr;
    logic [NFLAG-1:0]  flags;
    logic [FULL_W-1:0] cnt;
    logic [FULL_W-1:0] duty_sh;
    logic [LEN_W-1:0]  len_sh;
    logic              wrap_lo, wrap_hi;

    tp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .clr(clr)
    );

    tp_count u_cnt (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cyc_stb(cyc_stb),
        .cnt(cnt), .duty_sh(duty_sh), .len_sh(len_sh),
        .wrap_lo(wrap_lo), .wrap_hi(wrap_hi)
    );

    tp_pwmcmp u_cmp (
        .mode(cfg.mode), .run_hi(cfg.run_hi), .cnt(cnt),
        .duty_sh(duty_sh), .pwm(pwm_out)
    );

    tp_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set({wrap_hi, wrap_lo}),
        .clr(clr), .flags(flags)
    );

    assign flag_lo = flags[0];
    assign flag_hi = flags[1];
    assign irq     = |flags;
endmodule

// File: rtl/tp_timer_pwm_chk.sv
module tp_timer_pwm_chk
    import tp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_stb,
    input logic              wr_en,
    input logic              clr_hi,
    input logic              pwm_out,
    input logic              flag_hi,
    input mode_e             mode,
    input logic              fast,
    input logic              run_lo,
    input logic              run_hi,
    input logic [FULL_W-1:0] cnt,
    input logic [LEN_W-1:0]  len_sh
);
    logic [FULL_W:0]   span;
    logic [FULL_W-1:0] last_val;

    assign span     = {{FULL_W{1'b0}}, 1'b1} << (HALF_W + 1 + int'(len_sh));
    assign last_val = span[FULL_W-1:0] - 1'b1;

    AST_TIMER_MODES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DUAL8 || mode == MODE_T16) |-> !pwm_out); // R8

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_DUAL8 || mode == MODE_T8_PWM8) && run_lo && !cyc_stb && !wr_en)
        |=> $stable(cnt[HALF_W-1:0])); // R5

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_T16 || mode == MODE_VPWM) && fast && run_hi && !wr_en)
        |=> (cnt == FULL_W'($past(cnt) + 1'b1) || cnt == '0)); // R6

    AST_VPWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_VPWM && run_hi && (fast || cyc_stb) && cnt >= last_val && !wr_en)
        |=> (cnt == '0 && flag_hi)); // R7

    AST_FLAG_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hi && !clr_hi) |=> flag_hi); // R10
endmodule

bind tp_timer_pwm tp_timer_pwm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .wr_en(wr_en),
    .clr_hi(clr[1]), .pwm_out(pwm_out), .flag_hi(flag_hi),
    .mode(cfg.mode), .fast(cfg.fast), .run_lo(cfg.run_lo), .run_hi(cfg.run_hi),
    .cnt(cnt), .len_sh(len_sh)
);

// File: tb/tb_tp_timer_pwm.sv
module tb_tp_timer_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, irq, flag_lo, flag_hi;

    int    compared = 0;
    int    mismatched = 0;
    int    stb_div = 2;
    bit    cmp_on = 0;
    bit    done = 0;
    string phase = "R1 reset state";

    // behavioural reference state
    int m_mode, m_fast, m_runlo, m_runhi, m_len, m_lop, m_hip, m_lod, m_hid;
    int m_lo, m_hi, m_dsh, m_lsh, m_flo, m_fhi;
    int sl, sh, w, mk;

    tp_timer_pwm dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
        .irq(irq), .flag_lo(flag_lo), .flag_hi(flag_hi)
    );

    always #5 clk = ~clk;

    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            cyc_stb = (k % stb_div) == 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_fast = 0; m_runlo = 0; m_runhi = 0; m_len = 0;
            m_lop = 0; m_hip = 0; m_lod = 0; m_hid = 0;
            m_lo = 0; m_hi = 0; m_dsh = 0; m_lsh = 0; m_flo = 0; m_fhi = 0;
            cmp_on = 1;
        end else begin
            sl = 0; sh = 0;
            w = m_hi * 256 + m_lo;
            if (m_runhi == 0) begin m_dsh = m_hid * 256 + m_lod; m_lsh = m_len; end
            if (m_mode < 2) begin
                if (m_runlo == 0) m_lo = 0;
                else if (cyc_stb) begin
                    if (m_lo >= m_lop) begin m_lo = 0; sl = 1; end else m_lo++;
                end
                if (m_runhi == 0) m_hi = 0;
                else if (cyc_stb) begin
                    if (m_mode == 0) begin
                        if (m_hi >= m_hip) begin m_hi = 0; sh = 1; end else m_hi++;
                    end else begin
                        if (m_hi == 255) begin
                            m_hi = 0; sh = 1; m_dsh = m_hid * 256 + (m_dsh % 256);
                        end else m_hi++;
                    end
                end
            end else begin
                mk = (m_mode == 2) ? (m_hip * 256 + m_lop) : ((1 << (m_lsh + 9)) - 1);
                if (m_runhi == 0) w = 0;
                else if (m_fast != 0 || cyc_stb) begin
                    if (w >= mk) begin
                        w = 0; sh = 1;
                        if (m_mode == 3) begin m_dsh = m_hid * 256 + m_lod; m_lsh = m_len; end
                    end else w++;
                end
                m_hi = w / 256; m_lo = w % 256;
            end
            m_flo = (sl != 0 || (m_flo != 0 && !(wr_en && wr_addr == 3'd6 && wr_data[0]))) ? 1 : 0;
            m_fhi = (sh != 0 || (m_fhi != 0 && !(wr_en && wr_addr == 3'd6 && wr_data[1]))) ? 1 : 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_mode = int'(wr_data[1:0]); m_fast = int'(wr_data[2]);
                        m_runlo = int'(wr_data[3]); m_runhi = int'(wr_data[4]);
                    end
                    3'd1: m_len = int'(wr_data[2:0]);
                    3'd2: m_lop = int'(wr_data);
                    3'd3: m_hip = int'(wr_data);
                    3'd4: m_lod = int'(wr_data);
                    3'd5: m_hid = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic check_bit(input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic e_pwm;
            e_pwm = (m_mode == 1 && m_runhi != 0 && m_hi < m_dsh / 256) ||
                    (m_mode == 3 && m_runhi != 0 && (m_hi * 256 + m_lo) < m_dsh);
            check_bit("pwm_out", pwm_out, e_pwm);
            check_bit("flag_lo", flag_lo, m_flo != 0);
            check_bit("flag_hi", flag_hi, m_fhi != 0);
            check_bit("irq", irq, (m_flo | m_fhi) != 0);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(5);

        phase = "R2 R11 dual timers";
        wr(3'd2, 8'd5); wr(3'd3, 8'd9); wr(3'd0, 8'h18);
        idle(80);
        phase = "R10 flag clear";
        wr(3'd6, 8'h01); idle(20); wr(3'd6, 8'h02); idle(20); wr(3'd6, 8'h03);
        wr(3'd0, 8'h08); idle(40); wr(3'd6, 8'h03); idle(5);

        phase = "R5 rate bit ignored in byte modes";
        wr(3'd0, 8'h00);
        stb_div = 3;
        wr(3'd0, 8'h1C); idle(90);
        stb_div = 2;
        wr(3'd0, 8'h00); wr(3'd6, 8'h03);

        phase = "R3 timer plus byte pwm";
        wr(3'd5, 8'd64); wr(3'd0, 8'h19); idle(300);
        phase = "R9 duty change mid period";
        wr(3'd5, 8'd200); idle(600);
        phase = "R8 zero duty byte pwm";
        wr(3'd5, 8'd0); idle(600);
        wr(3'd0, 8'h00); wr(3'd6, 8'h03);

        phase = "R4 sixteen-bit timer";
        wr(3'd2, 8'h2C); wr(3'd3, 8'h01); wr(3'd0, 8'h12); idle(700);
        phase = "R6 fast sixteen-bit timer";
        wr(3'd0, 8'h00); wr(3'd0, 8'h16); idle(700);
        wr(3'd0, 8'h00); wr(3'd6, 8'h03);

        phase = "R7 variable pwm nine bits";
        wr(3'd1, 8'd0); wr(3'd4, 8'd100); wr(3'd5, 8'd0); wr(3'd0, 8'h17); idle(1200);
        phase = "R9 length and duty change at wrap";
        wr(3'd1, 8'd2); wr(3'd4, 8'd0); wr(3'd5, 8'd3); idle(2600);
        phase = "R6 slow variable pwm";
        wr(3'd0, 8'h13); idle(4300);
        phase = "R8 zero duty wide pwm";
        wr(3'd4, 8'd0); wr(3'd5, 8'd0); idle(4300);
        wr(3'd0, 8'h00); idle(5);

        phase = "R7 sixteen-bit length";
        wr(3'd1, 8'd7); wr(3'd4, 8'd0); wr(3'd5, 8'h80); wr(3'd0, 8'h17);
        idle(66000);
        phase = "R8 stopped output low";
        wr(3'd0, 8'h03); idle(10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL %s watchdog: actual=running expected=finished", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule